// File: doc/BRIEF.md
# ADC Conversion Timer

This block derives every timing signal for a single analog-to-digital conversion from one fast system clock. A prescaler divides the system clock into an ADC clock enable. Two further settings define the conversion clock rate and stretch the sample-and-hold window. When a start request arrives while the block is idle, the three settings are captured. The block then raises a sample strobe for the programmed window. Next it plays out thirteen conversion clock periods, each with a bit index for a downstream successive-approximation register. A one-cycle done pulse closes the sequence.

Two combinational flags warn when a setting breaks the converter's timing limits. One flag covers a conversion clock faster than 2 MHz. The other covers a sample-and-hold window shorter than 40 µs. Both are computed from the system clock frequency, which is a parameter. While idle the flags follow the live setting inputs. While busy they follow the captured settings.

Top module: `adc_conv_timer`

## Requirements
- R1: `adc_tick_o` is high for one system clock out of every (`clk_div_i` + 1). The prescaler restarts on an accepted start.
- R2: A start accepted in idle raises `busy_o` in the next cycle. From that cycle `sample_o` stays high for exactly W × (`clk_div_i` + 1) system clocks, where W = 2 × (`rate_div_i` + 1 + `samp_div_i`).
- R3: When the window ends, `conv_clk_o` goes high and toggles every (`rate_div_i` + 1) ADC ticks. This gives exactly 13 full periods, each starting with a high half. `conv_clk_o` is low outside this phase and is never high together with `sample_o`.
- R4: `bit_idx_o` reads 12 during the first conversion period and drops by one at each following period start, reaching 0 in the last period. It is 0 in idle and changes only in cycles that follow an ADC tick.
- R5: `done_o` is a single-cycle pulse 26 × (`rate_div_i` + 1) × (`clk_div_i` + 1) system clocks after `sample_o` falls. `busy_o` falls in that same cycle.
- R6: A start request while `busy_o` is high is ignored and leaves the timing unchanged.
- R7: The three divider settings are captured on the accepted start. Changing the inputs while busy has no effect on timing or flags.
- R8: `rate_err_o` is high when SYS_CLK_HZ > 2 MHz × 2 × (`rate_div_i` + 1) × (`clk_div_i` + 1). Exactly 2 MHz is not an error.
- R9: `window_err_o` is high when W × (`clk_div_i` + 1) / SYS_CLK_HZ is below 40 µs. Exactly 40 µs is not an error.
- R10: While `rst_ni` is low the block is idle, with `busy_o`, `sample_o`, `conv_clk_o`, `done_o` and `bit_idx_o` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| clk_div_i | input | 8 | System-to-ADC clock divider setting |
| rate_div_i | input | 8 | Conversion clock rate setting |
| samp_div_i | input | 8 | Extra sample-and-hold length setting |
| adc_tick_o | output | 1 | ADC clock enable |
| sample_o | output | 1 | Sample-and-hold strobe |
| conv_clk_o | output | 1 | Conversion clock, 50% duty |
| bit_idx_o | output | 4 | Current result bit, 12 down to 0 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| rate_err_o | output | 1 | Conversion clock above 2 MHz |
| window_err_o | output | 1 | Sample window below 40 µs |

## Verification
The assertions assume that `start_i` and the divider inputs are synchronous to `clk_i`. They also assume that the done and bit-index sequencing is only observed after reset has been released. They do not restrict when `start_i` may rise, because a request while busy must be harmless. The stimulus changes every input half a period away from the active edge. During chosen runs it deliberately pulses `start_i` and rewrites all three settings while busy, which exercises the ignore and capture behaviour without breaking the synchronous-input assumption.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV
  } seq_state_e;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the period bounded if div_i shrinks while idle
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_limit_check.sv
module adc_limit_check #(
  parameter int              DIV_W       = 8,
  parameter longint unsigned SYS_CLK_HZ  = 144_000_000,
  parameter longint unsigned MAX_CONV_HZ = 2_000_000,
  parameter longint unsigned MIN_WIN_NS  = 40_000
) (
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic [DIV_W-1:0] rate_div_i,
  input  logic [DIV_W-1:0] samp_div_i,
  output logic             rate_err_o,
  output logic             window_err_o
);
  localparam logic [63:0] NS_PER_S = 64'd1_000_000_000;

  logic [63:0] d_p1, r_p1, win;

  always_comb begin
    d_p1 = 64'(clk_div_i) + 64'd1;
    r_p1 = 64'(rate_div_i) + 64'd1;
    win  = (r_p1 + 64'(samp_div_i)) << 1;
    // conv freq = SYS / (2*(r+1)*(d+1)); compare without division
    rate_err_o   = SYS_CLK_HZ > (MAX_CONV_HZ * 64'd2 * r_p1 * d_p1);
    // window ns = win*(d+1)*1e9 / SYS
    window_err_o = (win * d_p1 * NS_PER_S) < (MIN_WIN_NS * SYS_CLK_HZ);
  end
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_conv_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int NUM_BITS = 13,
  parameter int IDX_W    = $clog2(NUM_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] rate_div_i,
  input  logic [DIV_W-1:0] samp_div_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             sample_o,
  output logic             conv_clk_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             done_o
);
  localparam int CNT_W = DIV_W + 2;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_BITS - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_len;
  logic             cclk_q, done_q;
  logic [IDX_W-1:0] idx_q;

  assign win_len    = (CNT_W'(rate_div_i) + CNT_W'(samp_div_i) + CNT_W'(1)) << 1;
  assign accept_o   = start_i && (state_q == ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign sample_o   = (state_q == ST_SAMPLE);
  assign conv_clk_o = cclk_q;
  assign bit_idx_o  = idx_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cclk_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
          end
        end
        ST_SAMPLE: begin
          if (tick_i) begin
            if (cnt_q == win_len - CNT_W'(1)) begin
              state_q <= ST_CONV;
              cnt_q   <= '0;
              cclk_q  <= 1'b1;
              idx_q   <= TOP_IDX;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (tick_i) begin
            if (cnt_q == CNT_W'(rate_div_i)) begin
              cnt_q <= '0;
              if (cclk_q) begin
                cclk_q <= 1'b0;
              end else if (idx_q == '0) begin
                // end of last low half: finish with clock held low
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                cclk_q <= 1'b1;
                idx_q  <= idx_q - 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int              DIV_W       = 8,
  parameter int              NUM_BITS    = 13,
  parameter longint unsigned SYS_CLK_HZ  = 144_000_000,
  parameter longint unsigned MAX_CONV_HZ = 2_000_000,
  parameter longint unsigned MIN_WIN_NS  = 40_000,
  parameter int              IDX_W       = $clog2(NUM_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic [DIV_W-1:0] rate_div_i,
  input  logic [DIV_W-1:0] samp_div_i,
  output logic             adc_tick_o,
  output logic             sample_o,
  output logic             conv_clk_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             rate_err_o,
  output logic             window_err_o
);
  logic [DIV_W-1:0] clk_div_q, rate_div_q, samp_div_q;
  logic [DIV_W-1:0] clk_div_e, rate_div_e, samp_div_e;
  logic             accept;

  // live settings in idle, captured settings while busy
  assign clk_div_e  = busy_o ? clk_div_q  : clk_div_i;
  assign rate_div_e = busy_o ? rate_div_q : rate_div_i;
  assign samp_div_e = busy_o ? samp_div_q : samp_div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_div_q  <= '0;
      rate_div_q <= '0;
      samp_div_q <= '0;
    end else if (accept) begin
      clk_div_q  <= clk_div_i;
      rate_div_q <= rate_div_i;
      samp_div_q <= samp_div_i;
    end
  end

  adc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .div_i     (clk_div_e),
    .tick_o    (adc_tick_o)
  );

  adc_phase_seq #(.DIV_W(DIV_W), .NUM_BITS(NUM_BITS), .IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tick_i     (adc_tick_o),
    .rate_div_i (rate_div_e),
    .samp_div_i (samp_div_e),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .sample_o   (sample_o),
    .conv_clk_o (conv_clk_o),
    .bit_idx_o  (bit_idx_o),
    .done_o     (done_o)
  );

  adc_limit_check #(
    .DIV_W(DIV_W), .SYS_CLK_HZ(SYS_CLK_HZ),
    .MAX_CONV_HZ(MAX_CONV_HZ), .MIN_WIN_NS(MIN_WIN_NS)
  ) u_lim (
    .clk_div_i    (clk_div_e),
    .rate_div_i   (rate_div_e),
    .samp_div_i   (samp_div_e),
    .rate_err_o   (rate_err_o),
    .window_err_o (window_err_o)
  );
endmodule

// File: rtl/adc_conv_timer_chk.sv
module adc_conv_timer_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             adc_tick_o,
  input logic             sample_o,
  input logic             conv_clk_o,
  input logic [IDX_W-1:0] bit_idx_o,
  input logic             busy_o,
  input logic             done_o
);
  assert_busy_needs_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_sample_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_o);

  assert_cclk_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_clk_o |-> busy_o);

  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_clk_o && sample_o));

  assert_idx_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_tick_o |=> $stable(bit_idx_o));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_ends_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind adc_conv_timer adc_conv_timer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .adc_tick_o (adc_tick_o),
  .sample_o   (sample_o),
  .conv_clk_o (conv_clk_o),
  .bit_idx_o  (bit_idx_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_adc_conv_timer.sv
module sim_adc_conv_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] clk_div_i = '0, rate_div_i = '0, samp_div_i = '0;
  logic       adc_tick_o, sample_o, conv_clk_o, busy_o, done_o, rate_err_o, window_err_o;
  logic [3:0] bit_idx_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  adc_conv_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .clk_div_i(clk_div_i), .rate_div_i(rate_div_i), .samp_div_i(samp_div_i),
    .adc_tick_o(adc_tick_o), .sample_o(sample_o), .conv_clk_o(conv_clk_o),
    .bit_idx_o(bit_idx_o), .busy_o(busy_o), .done_o(done_o),
    .rate_err_o(rate_err_o), .window_err_o(window_err_o)
  );

  typedef struct packed {
    logic [7:0] d;
    logic [7:0] r;
    logic [7:0] s;
    logic       er;
    logic       ew;
  } vec_t;

  // expected flags from R8/R9 at SYS_CLK_HZ = 144 MHz
  localparam vec_t VECS [9] = '{
    '{8'd0,   8'd0,  8'd0,  1'b1, 1'b1},
    '{8'd1,   8'd2,  8'd3,  1'b1, 1'b1},
    '{8'd3,   8'd1,  8'd0,  1'b1, 1'b1},
    '{8'd7,   8'd15, 8'd1,  1'b0, 1'b1},
    '{8'd255, 8'd0,  8'd11, 1'b0, 1'b0},
    '{8'd239, 8'd0,  8'd11, 1'b0, 1'b0},  // window exactly 40 us
    '{8'd239, 8'd0,  8'd10, 1'b0, 1'b1},
    '{8'd4,   8'd5,  8'd0,  1'b1, 1'b1},
    '{8'd5,   8'd5,  8'd0,  1'b0, 1'b1}   // conv clock exactly 2 MHz
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input vec_t v, input bit disturb);
    int n, cyc, rises, guard;
    bit prev;
    longint w_len;
    w_len = 2 * (longint'(v.r) + 1 + longint'(v.s));
    @(negedge clk_i);
    clk_div_i = v.d; rate_div_i = v.r; samp_div_i = v.s;
    @(negedge clk_i);
    chk(rate_err_o == v.er, "R8 idle rate flag", rate_err_o, v.er);
    chk(window_err_o == v.ew, "R9 idle window flag", window_err_o, v.ew);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    n = 0; guard = 0;
    while (sample_o && guard < 100000) begin
      n++; guard++;
      if (disturb && n == 1) begin
        start_i = 1'b1;
        clk_div_i = 8'd255; rate_div_i = 8'd0; samp_div_i = 8'd11;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      if (disturb && n == 1) begin
        chk(rate_err_o == v.er, "R7 captured rate flag", rate_err_o, v.er);
        chk(window_err_o == v.ew, "R7 captured window flag", window_err_o, v.ew);
      end
    end
    start_i = 1'b0;
    chk(n == w_len * (v.d + 1), disturb ? "R6 R7 sample length" : "R2 sample length",
        n, w_len * (v.d + 1));
    cyc = 0; rises = 0; prev = 1'b0; guard = 0;
    while (!done_o && guard < 100000) begin
      guard++;
      if (conv_clk_o && !prev) begin
        chk(bit_idx_o == 4'(12 - rises), "R4 bit index", bit_idx_o, 12 - rises);
        rises++;
      end
      chk(!sample_o, "R3 no sample in conversion", sample_o, 0);
      prev = conv_clk_o;
      cyc++;
      if (disturb && cyc == 5) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    chk(cyc == 26 * (v.r + 1) * (v.d + 1), "R5 conversion length", cyc,
        26 * (v.r + 1) * (v.d + 1));
    chk(rises == 13, "R3 conversion clock periods", rises, 13);
    chk(done_o && !busy_o, "R5 done with busy low", {done_o, busy_o}, 2);
    chk(!conv_clk_o && bit_idx_o == 0, "R3 R4 idle after done", {conv_clk_o, bit_idx_o}, 0);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R5 done single cycle", {done_o, busy_o}, 0);
  endtask

  initial begin
    int gap;
    // R10: reset state
    @(negedge clk_i);
    chk({busy_o, sample_o, conv_clk_o, done_o, bit_idx_o} == 0, "R10 reset outputs",
        {busy_o, sample_o, conv_clk_o, done_o, bit_idx_o}, 0);
    rst_ni = 1'b1;

    // R1: tick period in idle
    clk_div_i = 8'd3;
    @(negedge clk_i);
    while (!adc_tick_o) @(negedge clk_i);
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      do begin @(negedge clk_i); gap++; end while (!adc_tick_o && gap < 1000);
      chk(gap == 4, "R1 tick period div 3", gap, 4);
    end
    clk_div_i = 8'd0;
    @(negedge clk_i);
    for (int k = 0; k < 3; k++) begin
      chk(adc_tick_o, "R1 tick every cycle div 0", adc_tick_o, 1);
      @(negedge clk_i);
    end

    // table walk
    for (int i = 0; i < 9; i++) run_conv(VECS[i], 1'b0);

    // R6 R7: start and setting changes while busy
    run_conv(VECS[1], 1'b1);

    // R10: reset in the middle of a conversion
    @(negedge clk_i);
    clk_div_i = 8'd3; rate_div_i = 8'd1; samp_div_i = 8'd0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (40) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk({busy_o, sample_o, conv_clk_o, done_o, bit_idx_o} == 0, "R10 reset mid conversion",
        {busy_o, sample_o, conv_clk_o, done_o, bit_idx_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R10 stays idle after reset", busy_o, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule